// File: doc/BRIEF.md
# Command Queue Arbiter

The block decides which of six command queues may hand its head command to the conversion engines in a given cycle. A queue takes part only after it has been armed. Arming comes from a one-cycle software pulse or from a hardware trigger pulse, and a hardware pulse is taken only if that queue's hardware enable is set. A queue stays armed while it holds commands. Among the queues that are armed and not empty, the one with the smallest index wins. The grant is one-hot and acts as the pop strobe for the winning queue. The selected command appears on a shared output.

Each head command carries a continuation bit, which marks that more commands of the same sequence follow. When a queue issues a command with this bit set, the block notes that the queue owns an open sequence. If a grant goes to any other queue before the owner issues the last command of its sequence, the sequence is broken. The block then sets a sticky per-queue coherency flag and drives a combined interrupt. Software clears a flag with a write-one-to-clear pulse.

Top module: `cmdq_arbiter`

## Requirements
- R1: A pulse on `sw_trig_i[i]`, or on `hw_trig_i[i]` while `hw_en_i[i]` is 1, sets `armed_o[i]` in the following cycle. A hardware pulse on a queue whose `hw_en_i` bit is 0 leaves `armed_o` unchanged.
- R2: Queue i can be granted only when `armed_o[i]` and `q_nempty_i[i]` are both 1 and `eng_ready_i` is 1. When `eng_ready_i` is 0, `gnt_o` is all zero.
- R3: When several queues are eligible, the grant goes to the eligible queue with the lowest index. Bit 0 has the highest priority.
- R4: `gnt_o` is combinational and has at most one bit set. `cmd_valid_o` equals the OR of `gnt_o`. `cmd_o` carries bits [i*CMD_W +: CMD_W] of `q_cmd_i` for the granted queue i, and is zero when there is no grant.
- R5: An armed queue whose `q_nempty_i` bit is 0 at a clock edge is disarmed at that edge. If a trigger arrives for that queue at the same edge, the trigger wins.
- R6: A grant to queue i with `q_cont_i[i]`=1 opens a sequence owned by i. Further grants to i keep the sequence open. A grant to i with `q_cont_i[i]`=0 closes it, and no flag is set.
- R7: While queue k owns an open sequence, a grant to any other queue j sets `coh_irq_o[k]` in the next cycle. After that grant, the new owner is j if `q_cont_i[j]`=1; otherwise no sequence is open.
- R8: A bit of `coh_irq_o` stays set until a pulse on the same bit of `irq_clr_i` clears it. A new break in the same cycle as the clear pulse keeps the bit set.
- R9: `irq_o` is the OR of all bits of `coh_irq_o`.
- R10: After reset, no queue is armed, no flag is set, no sequence is open, and `gnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_trig_i | input | NUM_Q | One-cycle software arm pulses, one per queue |
| hw_trig_i | input | NUM_Q | Hardware arm pulses, one per queue |
| hw_en_i | input | NUM_Q | Per-queue enable for hardware arming |
| q_nempty_i | input | NUM_Q | Queue holds at least one command |
| q_cont_i | input | NUM_Q | Head command has more commands of its sequence after it |
| q_cmd_i | input | NUM_Q*CMD_W | Head commands of all queues, queue i at [i*CMD_W +: CMD_W] |
| eng_ready_i | input | 1 | Conversion engines can accept a command |
| irq_clr_i | input | NUM_Q | Write-one-to-clear pulses for the coherency flags |
| gnt_o | output | NUM_Q | One-hot grant, also the pop strobe |
| cmd_valid_o | output | 1 | A command is issued this cycle |
| cmd_o | output | CMD_W | Command of the granted queue |
| armed_o | output | NUM_Q | Per-queue armed state |
| coh_irq_o | output | NUM_Q | Sticky per-queue coherency-broken flags |
| irq_o | output | 1 | Any coherency flag set |

## Verification
Directed phases test the arbiter in four situations. The first is a single armed queue, which checks that arming and the ready gate work. The second is two armed queues at once, where only the priority order decides the winner. The third is a queue that empties while a lower-priority queue is waiting, which separates eligibility from the armed state. The fourth is a sequence from a low queue that is preempted, and is compared with a sequence that completes without interruption; the pair shows that only real breaks set a flag. A long random phase then drives triggers, empty flags, continuation bits, ready and clears all at once, so that preemption, emptying and clearing can fall in the same cycle. A behavioural model checks every output on every cycle of this phase.

// File: rtl/cmdq_arb_pkg.sv
`timescale 1ns/1ps
package cmdq_arb_pkg;
  parameter int unsigned DEF_NUM_Q = 6;
  parameter int unsigned DEF_CMD_W = 16;
endpackage

// File: rtl/cmdq_arm.sv
`timescale 1ns/1ps
module cmdq_arm #(
  parameter int unsigned NUM_Q = cmdq_arb_pkg::DEF_NUM_Q
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_Q-1:0] sw_trig_i,
  input  logic [NUM_Q-1:0] hw_trig_i,
  input  logic [NUM_Q-1:0] hw_en_i,
  input  logic [NUM_Q-1:0] q_nempty_i,
  output logic [NUM_Q-1:0] armed_o
);
  logic [NUM_Q-1:0] armed_q;
  logic [NUM_Q-1:0] arm_set;

  assign arm_set = sw_trig_i | (hw_trig_i & hw_en_i);

  // trigger wins over disarm on empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= '0;
    else         armed_q <= arm_set | (armed_q & q_nempty_i);
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/cmdq_prio.sv
`timescale 1ns/1ps
module cmdq_prio #(
  parameter int unsigned NUM_Q = cmdq_arb_pkg::DEF_NUM_Q
) (
  input  logic [NUM_Q-1:0] req_i,
  output logic [NUM_Q-1:0] gnt_o
);
  logic [NUM_Q-1:0] blk;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign blk[i] = 1'b0;
    end else begin : g_rest
      assign blk[i] = blk[i-1] | req_i[i-1];
    end
    assign gnt_o[i] = req_i[i] & ~blk[i];
  end
endmodule

// File: rtl/cmdq_coh.sv
`timescale 1ns/1ps
module cmdq_coh #(
  parameter int unsigned NUM_Q = cmdq_arb_pkg::DEF_NUM_Q
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_Q-1:0] gnt_i,
  input  logic [NUM_Q-1:0] cont_i,
  input  logic [NUM_Q-1:0] clr_i,
  output logic [NUM_Q-1:0] irq_o
);
  logic [NUM_Q-1:0] owner_q, owner_d;
  logic [NUM_Q-1:0] irq_q, brk;
  logic             any_gnt;

  assign any_gnt = |gnt_i;
  // owner is one-hot or zero (no open sequence)
  assign brk     = any_gnt ? (owner_q & ~gnt_i) : '0;
  assign owner_d = any_gnt ? (gnt_i & cont_i) : owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= '0;
      irq_q   <= '0;
    end else begin
      owner_q <= owner_d;
      irq_q   <= (irq_q & ~clr_i) | brk;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmdq_arbiter.sv
`timescale 1ns/1ps
module cmdq_arbiter #(
  parameter int unsigned NUM_Q = cmdq_arb_pkg::DEF_NUM_Q,
  parameter int unsigned CMD_W = cmdq_arb_pkg::DEF_CMD_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_Q-1:0]       sw_trig_i,
  input  logic [NUM_Q-1:0]       hw_trig_i,
  input  logic [NUM_Q-1:0]       hw_en_i,
  input  logic [NUM_Q-1:0]       q_nempty_i,
  input  logic [NUM_Q-1:0]       q_cont_i,
  input  logic [NUM_Q*CMD_W-1:0] q_cmd_i,
  input  logic                   eng_ready_i,
  input  logic [NUM_Q-1:0]       irq_clr_i,
  output logic [NUM_Q-1:0]       gnt_o,
  output logic                   cmd_valid_o,
  output logic [CMD_W-1:0]       cmd_o,
  output logic [NUM_Q-1:0]       armed_o,
  output logic [NUM_Q-1:0]       coh_irq_o,
  output logic                   irq_o
);
  logic [NUM_Q-1:0] armed, elig, gnt, flags;

  cmdq_arm #(.NUM_Q(NUM_Q)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_trig_i  (sw_trig_i),
    .hw_trig_i  (hw_trig_i),
    .hw_en_i    (hw_en_i),
    .q_nempty_i (q_nempty_i),
    .armed_o    (armed)
  );

  assign elig = armed & q_nempty_i & {NUM_Q{eng_ready_i}};

  cmdq_prio #(.NUM_Q(NUM_Q)) u_prio (
    .req_i (elig),
    .gnt_o (gnt)
  );

  cmdq_coh #(.NUM_Q(NUM_Q)) u_coh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gnt_i  (gnt),
    .cont_i (q_cont_i),
    .clr_i  (irq_clr_i),
    .irq_o  (flags)
  );

  always_comb begin
    cmd_o = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (gnt[i]) cmd_o = cmd_o | q_cmd_i[i*CMD_W +: CMD_W];
    end
  end

  assign gnt_o       = gnt;
  assign cmd_valid_o = |gnt;
  assign armed_o     = armed;
  assign coh_irq_o   = flags;
  assign irq_o       = |flags;
endmodule

// File: rtl/cmdq_arbiter_chk.sv
`timescale 1ns/1ps
module cmdq_arbiter_chk #(
  parameter int unsigned NUM_Q = cmdq_arb_pkg::DEF_NUM_Q,
  parameter int unsigned CMD_W = cmdq_arb_pkg::DEF_CMD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NUM_Q-1:0] sw_trig_i,
  input logic [NUM_Q-1:0] hw_trig_i,
  input logic [NUM_Q-1:0] hw_en_i,
  input logic [NUM_Q-1:0] q_nempty_i,
  input logic             eng_ready_i,
  input logic [NUM_Q-1:0] irq_clr_i,
  input logic [NUM_Q-1:0] gnt_o,
  input logic             cmd_valid_o,
  input logic [NUM_Q-1:0] armed_o,
  input logic [NUM_Q-1:0] coh_irq_o,
  input logic             irq_o
);
  p_arm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sw_trig_i | (hw_trig_i & hw_en_i)) & ~armed_o) == '0));

  p_gnt_elig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~(armed_o & q_nempty_i)) == '0);

  p_gnt_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_ready_i |-> gnt_o == '0);

  p_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> (((gnt_o - NUM_Q'(1)) & armed_o & q_nempty_i) == '0));

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o == (gnt_o != '0));

  p_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((armed_o & $past(~q_nempty_i & ~sw_trig_i & ~(hw_trig_i & hw_en_i))) == '0));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(coh_irq_o & ~irq_clr_i) & ~coh_irq_o) == '0));

  p_irq_any_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (coh_irq_o != '0));
endmodule

bind cmdq_arbiter cmdq_arbiter_chk #(.NUM_Q(NUM_Q), .CMD_W(CMD_W)) u_chk (.*);

// File: tb/cmdq_arbiter_tb.sv
`timescale 1ns/1ps
module cmdq_arbiter_tb;
  localparam int NQ = 6;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NQ-1:0] sw_trig = '0, hw_trig = '0, hw_en = '0, nempty = '0, cont = '0, clr = '0;
  logic ready = 1'b0;
  logic [NQ*CW-1:0] q_cmd;
  logic [NQ-1:0] gnt, armed, cirq;
  logic cvalid, irq;
  logic [CW-1:0] cmd;

  int checks = 0, errors = 0;
  bit done = 0, live = 0;

  always #2.5 clk = ~clk;

  cmdq_arbiter #(.NUM_Q(NQ), .CMD_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_trig_i(sw_trig), .hw_trig_i(hw_trig),
    .hw_en_i(hw_en), .q_nempty_i(nempty), .q_cont_i(cont), .q_cmd_i(q_cmd),
    .eng_ready_i(ready), .irq_clr_i(clr), .gnt_o(gnt), .cmd_valid_o(cvalid),
    .cmd_o(cmd), .armed_o(armed), .coh_irq_o(cirq), .irq_o(irq)
  );

  initial for (int i = 0; i < NQ; i++) q_cmd[i*CW +: CW] = CW'(16'hA5_00 + 16'(i * 7));

  // behavioural reference
  logic [NQ-1:0] m_armed, m_irq;
  int m_owner;

  function automatic int win_idx();
    if (!ready) return -1;
    for (int i = 0; i < NQ; i++) if (m_armed[i] && nempty[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = '0; m_irq = '0; m_owner = -1;
    end else begin
      int w;
      logic [NQ-1:0] brk;
      w = win_idx();
      brk = '0;
      if (w >= 0) begin
        if (m_owner >= 0 && m_owner != w) brk[m_owner] = 1'b1;
        m_owner = cont[w] ? w : -1;
      end
      m_irq = (m_irq & ~clr) | brk;
      m_armed = sw_trig | (hw_trig & hw_en) | (m_armed & nempty);
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      int w;
      logic [NQ-1:0] eg;
      logic [CW-1:0] ec;
      w = win_idx();
      eg = (w >= 0) ? NQ'(1) << w : '0;
      ec = (w >= 0) ? q_cmd[w*CW +: CW] : '0;
      chk(gnt === eg, "R3 grant vs model", gnt, eg);
      chk(cmd === ec && cvalid === (w >= 0), "R4 command vs model", {cvalid, cmd}, {(w >= 0), ec});
      chk(armed === m_armed, "R5 armed vs model", armed, m_armed);
      chk(cirq === m_irq, "R7 flags vs model", cirq, m_irq);
      chk(irq === (m_irq != '0), "R9 irq vs model", irq, (m_irq != '0));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    sw_trig = '0; hw_trig = '0; clr = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(armed === '0 && cirq === '0 && gnt === '0, "R10 reset state", {armed, cirq, gnt}, 0);
    rst_n = 1'b1;
    live = 1;
    nempty = '1;
    tick();

    // R1: hardware pulse ignored without enable, taken with it
    hw_trig[1] = 1'b1; tick();
    chk(armed[1] === 1'b0, "R1 hw trigger masked", armed[1], 0);
    hw_en[1] = 1'b1; hw_trig[1] = 1'b1; tick();
    chk(armed[1] === 1'b1, "R1 hw trigger enabled", armed[1], 1);
    chk(gnt === '0, "R2 no grant while not ready", gnt, 0);
    sw_trig[4] = 1'b1; tick();
    chk(armed === 6'b010010, "R1 sw trigger", armed, 6'b010010);
    ready = 1'b1; #1;
    chk(gnt === 6'b000010, "R3 lower index wins", gnt, 6'b000010);
    chk(cmd === q_cmd[1*CW +: CW], "R4 granted command", cmd, q_cmd[1*CW +: CW]);
    nempty[1] = 1'b0; #1;
    chk(gnt === 6'b010000, "R2 empty queue skipped", gnt, 6'b010000);
    ready = 1'b0; tick();
    chk(armed[1] === 1'b0, "R5 empty queue disarmed", armed[1], 0);

    // R7: sequence from queue 4 broken by queue 0
    cont[4] = 1'b1; ready = 1'b1; tick();
    ready = 1'b0; sw_trig[0] = 1'b1; tick();
    ready = 1'b1; #1;
    chk(gnt === 6'b000001, "R3 preempting grant", gnt, 6'b000001);
    tick(); ready = 1'b0;
    chk(cirq === 6'b010000, "R7 break flags owner", cirq, 6'b010000);
    chk(irq === 1'b1, "R9 irq raised", irq, 1);
    tick(); tick();
    chk(cirq[4] === 1'b1, "R8 flag sticky", cirq[4], 1);
    clr[4] = 1'b1; tick();
    chk(cirq === '0 && irq === 1'b0, "R8 cleared", {irq, cirq}, 0);

    // R8: set wins over clear
    nempty[0] = 1'b0; tick();
    ready = 1'b1; tick();
    ready = 1'b0; nempty[0] = 1'b1; sw_trig[0] = 1'b1; tick();
    ready = 1'b1; clr[4] = 1'b1; tick();
    ready = 1'b0;
    chk(cirq[4] === 1'b1, "R8 set beats clear", cirq[4], 1);
    clr = '1; tick();

    // R6: complete sequence, no flag
    nempty[0] = 1'b0; tick();
    ready = 1'b1; tick(); tick();
    cont[4] = 1'b0; tick();
    ready = 1'b0; nempty[0] = 1'b1; sw_trig[0] = 1'b1; tick();
    ready = 1'b1; tick(); ready = 1'b0;
    chk(cirq === '0, "R6 complete sequence unflagged", cirq, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      sw_trig = NQ'($urandom) & NQ'($urandom) & NQ'($urandom);
      hw_trig = NQ'($urandom) & NQ'($urandom);
      if (n % 97 == 0) hw_en = NQ'($urandom);
      nempty  = NQ'($urandom) | NQ'($urandom);
      cont    = NQ'($urandom);
      ready   = ($urandom % 4) != 0;
      clr     = ($urandom % 8 == 0) ? NQ'($urandom) : '0;
      @(posedge clk); #1;
    end
    sw_trig = '0; hw_trig = '0; clr = '0;

    tick(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule